// File: doc/BRIEF.md
# Control/Status Register Access Executor

This block carries out the six instructions that read and modify control/status registers: swap, bit-set and bit-clear, each in a register-operand form and a 5-bit immediate form. In the cycle an instruction word arrives, it decodes the word and checks the access against the current privilege level. If the access is allowed, it issues a combinational read to an attached register file and computes the new value. One clock later, it presents the register-file write, the destination general-register write, and either a retired or an illegal-instruction flag.

The block sits between an instruction issue stage and a CSR storage array. The array must return read data in the same cycle as the read strobe. The storage, trap entry and the surrounding pipeline belong to other blocks.

Top module: `csr_exec_unit`

## Requirements
- R1: An instruction is recognised only when `instr_valid` is 1, bits [6:0] equal 7'b1110011 and bits [13:12] are not 2'b00. Any other word produces no read strobe, no write, no destination write, no illegal flag and no retired flag.
- R2: Bit 14 set selects the immediate form. The operand is then the 5-bit field [19:15] zero-extended to XLEN. Otherwise the operand is `rs1_value`.
- R3: Bits [13:12] select the operation. 01 writes the operand. 10 writes the old value OR the operand. 11 writes the old value AND the inverted operand.
- R4: Swap (01) always writes the CSR. Set (10) and clear (11) write only when field [19:15] is nonzero. In the register form this tests the register index, not the register value.
- R5: The destination register, field [11:7], receives the CSR value read before any write. No destination write is issued when the field is 0.
- R6: For every recognised and permitted instruction, `csr_rd_en` is 1 in the decode cycle and `csr_raddr` equals bits [31:20]. This includes a swap with destination 0.
- R7: The access is refused when `priv` is below address bits [9:8]. It is also refused when a write is intended and address bits [11:10] equal 2'b11.
- R8: A refused access sets `illegal` and clears `retired` one cycle later. It issues no CSR write, no destination write and no read strobe.
- R9: All outputs except the read port are registered and appear one cycle after the instruction. After synchronous reset every output flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| instr_valid | input | 1 | instruction word is present |
| instr | input | 32 | instruction word |
| rs1_value | input | XLEN | value of the source general register |
| priv | input | 2 | current privilege level |
| csr_rdata | input | XLEN | same-cycle read data from the CSR file |
| csr_rd_en | output | 1 | CSR read strobe (combinational) |
| csr_raddr | output | 12 | CSR read address (combinational) |
| csr_we | output | 1 | CSR write enable |
| csr_waddr | output | 12 | CSR write address |
| csr_wdata | output | XLEN | CSR write data |
| rd_we | output | 1 | destination register write enable |
| rd_addr | output | 5 | destination register index |
| rd_data | output | XLEN | destination register data |
| illegal | output | 1 | illegal-instruction indication |
| retired | output | 1 | instruction completed |

## Verification
The bench uses the default XLEN of 32. It sweeps every one of the 16 values of address bits [11:8] against all four privilege levels, all six operations, source fields 0, 1 and 31, and destinations 0 and 5. This reaches every combination of the privilege rule, the read-only rule and the write-suppression rule. The register values differ from vector to vector. The x0-versus-zero-value distinction is covered by pairing a zero source index with a nonzero register value, and a nonzero index with a zero register value. Words with a foreign opcode, with bits [13:12] equal to 00, and with the valid flag low are also checked.

// File: rtl/csrx_pkg.sv
package csrx_pkg;
  localparam logic [6:0] SYS_OPCODE = 7'b1110011;
  localparam int         PRIV_W     = 2;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_SWAP = 2'b01,
    OP_SET  = 2'b10,
    OP_CLR  = 2'b11
  } csr_op_e;

  typedef struct packed {
    logic        hit;
    logic        imm;
    csr_op_e     op;
    logic [11:0] addr;
    logic [4:0]  src;
    logic [4:0]  dst;
    logic        wr_intent;
  } csr_dec_t;
endpackage

// File: rtl/csrx_decode.sv
module csrx_decode
  import csrx_pkg::*;
(
  input  logic [31:0] instr,
  output csr_dec_t    dec
);
  always_comb begin
    dec.op        = csr_op_e'(instr[13:12]);
    dec.hit       = (instr[6:0] == SYS_OPCODE) && (instr[13:12] != 2'b00);
    dec.imm       = instr[14];
    dec.addr      = instr[31:20];
    dec.src       = instr[19:15];
    dec.dst       = instr[11:7];
    // swap always writes; set/clear only with a nonzero source field
    dec.wr_intent = (dec.op == OP_SWAP) || (dec.src != 5'd0);
  end
endmodule

// File: rtl/csrx_permit.sv
module csrx_permit
  import csrx_pkg::*;
(
  input  logic [11:0]       addr,
  input  logic [PRIV_W-1:0] priv,
  input  logic              wr_intent,
  output logic              ok
);
  logic priv_ok, ro_hit;
  always_comb begin
    priv_ok = (priv >= addr[9:8]);
    ro_hit  = wr_intent && (addr[11:10] == 2'b11);
    ok      = priv_ok && !ro_hit;
  end
endmodule

// File: rtl/csrx_alu.sv
module csrx_alu
  import csrx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_op_e         op,
  input  logic            imm,
  input  logic [4:0]      src,
  input  logic [XLEN-1:0] rs1_value,
  input  logic [XLEN-1:0] old_value,
  output logic [XLEN-1:0] new_value
);
  localparam int PAD = XLEN - 5;
  logic [XLEN-1:0] operand;

  always_comb begin
    operand = imm ? {{PAD{1'b0}}, src} : rs1_value;
    unique case (op)
      OP_SWAP: new_value = operand;
      OP_SET:  new_value = old_value | operand;
      OP_CLR:  new_value = old_value & ~operand;
      default: new_value = old_value;
    endcase
  end
endmodule

// File: rtl/csr_exec_unit.sv
module csr_exec_unit
  import csrx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [31:0]       instr,
  input  logic [XLEN-1:0]   rs1_value,
  input  logic [1:0]        priv,
  input  logic [XLEN-1:0]   csr_rdata,
  output logic              csr_rd_en,
  output logic [11:0]       csr_raddr,
  output logic              csr_we,
  output logic [11:0]       csr_waddr,
  output logic [XLEN-1:0]   csr_wdata,
  output logic              rd_we,
  output logic [4:0]        rd_addr,
  output logic [XLEN-1:0]   rd_data,
  output logic              illegal,
  output logic              retired
);
  csr_dec_t        dec;
  logic            allowed, hit, go;
  logic [XLEN-1:0] next_value;

  csrx_decode u_dec (.instr(instr), .dec(dec));

  csrx_permit u_perm (
    .addr(dec.addr), .priv(priv), .wr_intent(dec.wr_intent), .ok(allowed)
  );

  csrx_alu #(.XLEN(XLEN)) u_alu (
    .op(dec.op), .imm(dec.imm), .src(dec.src), .rs1_value(rs1_value),
    .old_value(csr_rdata), .new_value(next_value)
  );

  assign hit       = instr_valid && dec.hit;
  assign go        = hit && allowed;
  assign csr_rd_en = go;
  assign csr_raddr = dec.addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      csr_we    <= 1'b0;
      csr_waddr <= '0;
      csr_wdata <= '0;
      rd_we     <= 1'b0;
      rd_addr   <= '0;
      rd_data   <= '0;
      illegal   <= 1'b0;
      retired   <= 1'b0;
    end else begin
      csr_we    <= go && dec.wr_intent;
      csr_waddr <= dec.addr;
      csr_wdata <= next_value;
      rd_we     <= go && (dec.dst != 5'd0);
      rd_addr   <= dec.dst;
      rd_data   <= csr_rdata;
      illegal   <= hit && !allowed;
      retired   <= go;
    end
  end

  // R8
  excl_flags_chk: assert property (@(posedge clk) disable iff (rst)
    !(illegal && retired));
  // R8
  refused_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!csr_we && !rd_we));
  // R7
  ro_guard_chk: assert property (@(posedge clk) disable iff (rst)
    csr_we |-> (csr_waddr[11:10] != 2'b11));
  // R5
  x0_drop_chk: assert property (@(posedge clk) disable iff (rst)
    rd_we |-> (rd_addr != 5'd0));
  // R9
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    csr_rd_en |=> retired);
  // R6
  strobe_addr_chk: assert property (@(posedge clk) disable iff (rst)
    retired |-> ($past(csr_raddr) == csr_waddr));
endmodule

// File: tb/sim_csr_exec_unit.sv
`timescale 1ns/1ps
module sim_csr_exec_unit;
  localparam int XLEN = 32;
  logic clk = 0, rst = 1;
  logic instr_valid = 0;
  logic [31:0] instr = '0;
  logic [XLEN-1:0] rs1_value = '0, csr_rdata = '0;
  logic [1:0] priv = '0;
  logic csr_rd_en, csr_we, rd_we, illegal, retired;
  logic [11:0] csr_raddr, csr_waddr;
  logic [XLEN-1:0] csr_wdata, rd_data;
  logic [4:0] rd_addr;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  csr_exec_unit #(.XLEN(XLEN)) u0 (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one vector, check strobe and next-cycle outputs against the model
  task automatic run(logic v, logic [31:0] w, logic [31:0] r1, logic [31:0] rdv, logic [1:0] p);
    logic rec, wr, ok, go;
    logic [31:0] opnd, nv;
    logic [1:0] op;
    @(negedge clk);
    instr_valid = v; instr = w; rs1_value = r1; csr_rdata = rdv; priv = p;
    op   = w[13:12];
    rec  = v && (w[6:0] == 7'b1110011) && (op != 2'b00);
    opnd = w[14] ? {27'd0, w[19:15]} : r1;
    wr   = (op == 2'b01) || (w[19:15] != 0);
    ok   = (p >= w[29:28]) && !(wr && w[31:30] == 2'b11);
    go   = rec && ok;
    nv   = (op == 2'b01) ? opnd : (op == 2'b10) ? (rdv | opnd) : (rdv & ~opnd);
    #1;
    check("R6 rd_en", csr_rd_en, go);
    if (go) check("R6 raddr", csr_raddr, w[31:20]);
    @(negedge clk);
    instr_valid = 0;
    check("R1/R4/R7 csr_we", csr_we, go && wr);
    if (go && wr) check("R3/R2 wdata", csr_wdata, nv);
    if (go && wr) check("R9 waddr", csr_waddr, w[31:20]);
    check("R5 rd_we", rd_we, go && (w[11:7] != 0));
    if (go && w[11:7] != 0) check("R5 rd_data", rd_data, rdv);
    check("R8 illegal", illegal, rec && !ok);
    check("R8 retired", retired, go);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset we", {csr_we, rd_we, illegal, retired}, 4'b0);
    rst = 0;
    for (int hi = 0; hi < 16; hi++)
      for (int p = 0; p < 4; p++)
        for (int f3 = 0; f3 < 8; f3++)
          for (int s = 0; s < 3; s++)
            for (int d = 0; d < 2; d++) begin
              logic [4:0] src;
              logic [31:0] w, r1, rv;
              if (f3[1:0] == 0) continue;
              src = (s == 0) ? 5'd0 : (s == 1) ? 5'd1 : 5'd31;
              w = {hi[3:0], 8'h5A, src, f3[2:0], (d == 0) ? 5'd0 : 5'd5, 7'b1110011};
              r1 = (s == 1) ? 32'd0 : 32'hA5C3_0F96 ^ (hi * 32'h0101_0101);
              rv = 32'h3C3C_F00F ^ (p * 32'h1111_0000) ^ f3;
              run(1'b1, w, r1, rv, p[1:0]);
            end
    // R1: funct3 low bits 00, foreign opcode, valid low
    run(1'b1, {12'h340, 5'd3, 3'b000, 5'd4, 7'b1110011}, 32'hFFFF, 32'h1234, 2'd3);
    run(1'b1, {12'h340, 5'd3, 3'b001, 5'd4, 7'b0110011}, 32'hFFFF, 32'h1234, 2'd3);
    run(1'b0, {12'h340, 5'd3, 3'b001, 5'd4, 7'b1110011}, 32'hFFFF, 32'h1234, 2'd3);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule